// File: doc/BRIEF.md
# Parallel NOR Flash Erase Sequencer

This block sits on the host side of a parallel x16 NOR flash bus and runs one erase per request. A requester presents an erase kind (whole chip, one sector, or one block) and a target word address. The block then drives six unlock and command word writes. Each write is strobed by WE# while CE# is held low.

After the command, the block polls the flash with OE#-strobed reads. The erase is finished once two reads in a row return the same level on DQ6 and on DQ2. If asked to, the block also waits for the ready/busy line to read high. It then pulses `done` for one clock. A poll budget bounds the wait: if the flash is still toggling when the budget runs out, the block reports an error with `done`.

All bus timings are counted in clock cycles and set by parameters. These are the WE# low width, the WE# high time, OE# setup before a read, the access time before the sample, and OE# hold after a read.

Top module: `nor_erase_seq`

## Requirements
- R1: After reset, and whenever idle, CE#, WE# and OE# are high, the data bus is not driven (`flash_dq_oe` low), and `busy`, `done` and `error` are low.
- R2: An accepted request starts six bus writes. The first five are, in order, address/data 555h/00AAh, 2AAh/0055h, 555h/0080h, 555h/00AAh, 2AAh/0055h.
- R3: The sixth write depends on `req_op`. `req_op`=00 (chip) gives 555h/0010h. `req_op`=01 (sector) gives the request address with 0050h. `req_op`=1x (block) gives the request address with 0030h. The upper data byte is always 00h.
- R4: Every write holds WE# low for exactly T_WP clocks, with address and data stable while WE# is low. WE# stays high for at least T_WPH clocks between writes. CE# is low for the whole operation.
- R5: The data bus is driven only during the write phase. OE# is never low while WE# is low or while the bus is driven.
- R6: Each poll read holds OE# low for T_ACC clocks and samples DQ6 and DQ2 at the end. Completion is recognised at the first read whose two bits both equal those of the read before it, so at least two reads are always made.
- R7: When `use_rdy` is high at the request, completion also needs `flash_ryby` high at the sample. When `use_rdy` is low, `flash_ryby` has no effect on when the block finishes.
- R8: If MAX_POLLS reads pass without completion, the block ends the operation with `done` and `error` both high.
- R9: A request made while `busy` is high is ignored. It causes no extra write and does not start a new operation afterwards.
- R10: `done` is high for exactly one clock. `busy` falls in that same clock, and `error` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Erase request, taken when idle |
| req_op | input | 2 | Erase kind: 00 chip, 01 sector, 1x block |
| req_addr | input | AW | Sector or block word address |
| use_rdy | input | 1 | Also wait for ready/busy high at completion |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| error | output | 1 | Poll budget ran out (valid with done) |
| flash_addr | output | AW | Flash word address |
| flash_dq_out | output | 16 | Write data to flash |
| flash_dq_oe | output | 1 | Drive enable for the data bus |
| flash_dq_in | input | 16 | Read data from flash |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_ryby | input | 1 | Ready (high) / busy (low) from flash |

## Verification
The flash model lets the status bits toggle for a chosen number of reads, so the bench knows the exact read on which the erase should end. An off-by-one in the compare shows up as a wrong read count. So does a design that compares against an unset first read, or one that checks only one of the two bits.

The ready line is held low well past the end of toggling. With `use_rdy` set, a design that ignores the line finishes early. With `use_rdy` clear, a design that still obeys the line finishes late.

A flash that never settles must end in exactly MAX_POLLS reads with the error flag set. A sixth write with the wrong address or code for a given erase kind is caught by the write scoreboard. So is a request raised mid-operation that leaks into extra writes or into a second operation.

// File: rtl/nor_erase_seq.sv
module nor_erase_seq #(
  parameter int AW        = 18,
  parameter int T_WP      = 3,
  parameter int T_WPH     = 2,
  parameter int T_OES     = 1,
  parameter int T_ACC     = 3,
  parameter int T_OEH     = 1,
  parameter int MAX_POLLS = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic          use_rdy,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] flash_addr,
  output logic [15:0]   flash_dq_out,
  output logic          flash_dq_oe,
  input  logic [15:0]   flash_dq_in,
  output logic          flash_ce_n,
  output logic          flash_we_n,
  output logic          flash_oe_n,
  input  logic          flash_ryby
);
  localparam int TMAX1 = (T_WP > T_WPH) ? T_WP : T_WPH;
  localparam int TMAX2 = (T_OES > T_ACC) ? T_OES : T_ACC;
  localparam int TMAX3 = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int TMAX  = (TMAX3 > T_OEH) ? TMAX3 : T_OEH;
  localparam int CW    = $clog2(TMAX + 1);
  localparam int PW    = $clog2(MAX_POLLS + 1);
  localparam logic [AW-1:0] A555 = AW'(18'h555);
  localparam logic [AW-1:0] A2AA = AW'(18'h2AA);

  typedef enum logic [2:0] {
    IDLE, WSET, WLOW, WHIGH, RSET, RACC, RHOLD
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [1:0]    op_q;
  logic [AW-1:0] tgt_q;
  logic          rdy_sel;
  logic [1:0]    prev, cur;
  logic          have_prev, fin, tout;
  logic [PW-1:0] polls;
  logic          settled;

  assign cur     = {flash_dq_in[6], flash_dq_in[2]};
  assign settled = have_prev && (cur == prev) && (!rdy_sel || flash_ryby);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      idx       <= '0;
      op_q      <= '0;
      tgt_q     <= '0;
      rdy_sel   <= 1'b0;
      prev      <= '0;
      have_prev <= 1'b0;
      fin       <= 1'b0;
      tout      <= 1'b0;
      polls     <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          op_q      <= req_op;
          tgt_q     <= req_addr;
          rdy_sel   <= use_rdy;
          idx       <= '0;
          have_prev <= 1'b0;
          fin       <= 1'b0;
          tout      <= 1'b0;
          polls     <= '0;
          st        <= WSET;
        end
        WSET: begin
          cnt <= CW'(T_WP - 1);
          st  <= WLOW;
        end
        WLOW:
          if (cnt == '0) begin
            cnt <= CW'(T_WPH - 1);
            st  <= WHIGH;
          end else cnt <= cnt - 1'b1;
        WHIGH:
          if (cnt == '0) begin
            if (idx == 3'd5) begin
              cnt <= CW'(T_OES - 1);
              st  <= RSET;
            end else begin
              idx <= idx + 1'b1;
              st  <= WSET;
            end
          end else cnt <= cnt - 1'b1;
        RSET:
          if (cnt == '0) begin
            cnt <= CW'(T_ACC - 1);
            st  <= RACC;
          end else cnt <= cnt - 1'b1;
        RACC:
          if (cnt == '0) begin
            prev      <= cur;
            have_prev <= 1'b1;
            polls     <= polls + 1'b1;
            if (settled) fin <= 1'b1;
            else if (polls == PW'(MAX_POLLS - 1)) tout <= 1'b1;
            cnt <= CW'(T_OEH - 1);
            st  <= RHOLD;
          end else cnt <= cnt - 1'b1;
        RHOLD:
          if (cnt == '0) begin
            if (fin || tout) begin
              done  <= 1'b1;
              error <= tout;
              st    <= IDLE;
            end else begin
              cnt <= CW'(T_OES - 1);
              st  <= RSET;
            end
          end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  always_comb begin
    flash_addr   = A555;
    flash_dq_out = 16'h0000;
    case (idx)
      3'd0: flash_dq_out = 16'h00AA;
      3'd1: begin flash_addr = A2AA; flash_dq_out = 16'h0055; end
      3'd2: flash_dq_out = 16'h0080;
      3'd3: flash_dq_out = 16'h00AA;
      3'd4: begin flash_addr = A2AA; flash_dq_out = 16'h0055; end
      default:
        if (op_q == 2'b00) flash_dq_out = 16'h0010;
        else begin
          flash_addr   = tgt_q;
          flash_dq_out = op_q[1] ? 16'h0030 : 16'h0050;
        end
    endcase
  end

  assign busy        = (st != IDLE);
  assign flash_ce_n  = !busy;
  assign flash_we_n  = (st != WLOW);
  assign flash_oe_n  = (st != RACC);
  assign flash_dq_oe = (st == WSET) || (st == WLOW) || (st == WHIGH);
endmodule

// File: rtl/nor_erase_seq_chk.sv
module nor_erase_seq_chk #(
  parameter int AW   = 18,
  parameter int T_WP = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic [AW-1:0] flash_addr,
  input logic [15:0]   flash_dq_out,
  input logic          flash_dq_oe,
  input logic          flash_ce_n,
  input logic          flash_we_n,
  input logic          flash_oe_n
);
  logic [7:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) low_cnt <= '0;
    else if (!flash_we_n) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;

  // R1
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe));
  // R4
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_we_n) |-> (low_cnt == 8'(T_WP)));
  // R4
  write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq_out)));
  // R4
  ce_during_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n || !flash_oe_n) |-> !flash_ce_n);
  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_oe_n |-> (flash_we_n && !flash_dq_oe));
  // R9
  stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> !busy);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R10
  error_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);
endmodule

bind nor_erase_seq nor_erase_seq_chk #(.AW(AW), .T_WP(T_WP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .error(error), .flash_addr(flash_addr), .flash_dq_out(flash_dq_out),
  .flash_dq_oe(flash_dq_oe), .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n),
  .flash_oe_n(flash_oe_n)
);

// File: tb/sim_nor_erase_seq.sv
module sim_nor_erase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int MAXP = 40;

  logic          clk = 0, rst_n = 0;
  logic          req_valid = 0, use_rdy = 0;
  logic [1:0]    req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic          busy, done, error, flash_dq_oe, flash_ce_n, flash_we_n, flash_oe_n;
  logic [AW-1:0] flash_addr;
  logic [15:0]   flash_dq_out, flash_dq_in;
  logic          flash_ryby;

  int vectors = 0, fails = 0;
  int reads = 0, base = 0, ntog = 0, nry = 0, k, t;
  logic [AW+15:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_erase_seq #(.AW(AW), .T_WP(3), .T_WPH(2), .T_OES(1), .T_ACC(2), .T_OEH(1),
                  .MAX_POLLS(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .use_rdy(use_rdy), .busy(busy), .done(done), .error(error),
    .flash_addr(flash_addr), .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
    .flash_dq_in(flash_dq_in), .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n),
    .flash_oe_n(flash_oe_n), .flash_ryby(flash_ryby));

  always @(negedge flash_oe_n) reads <= reads + 1;
  assign k = reads - base;
  assign t = (k < ntog) ? k : ntog;
  assign flash_dq_in = {9'b0, t[0], 3'b0, t[0], 2'b0};
  assign flash_ryby  = (k >= nry);

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge flash_we_n) if (rst_n) begin
    logic [AW+15:0] e;
    if (expq.size() == 0) check(0, "R9", "unexpected write", {flash_addr, flash_dq_out}, 0);
    else begin
      e = expq.pop_front();
      check({flash_addr, flash_dq_out} == e, "R2/R3", "write addr,data",
            {flash_addr, flash_dq_out}, e);
      check(!flash_ce_n && flash_dq_oe, "R4", "ce low and bus driven",
            {flash_ce_n, flash_dq_oe}, 2'b01);
    end
  end

  task automatic run_op(logic [1:0] op, logic [AW-1:0] a, int nt, int nr, bit ur,
                        bit exp_err, bit intrude);
    int want, cyc;
    expq.push_back({AW'(18'h555), 16'h00AA});
    expq.push_back({AW'(18'h2AA), 16'h0055});
    expq.push_back({AW'(18'h555), 16'h0080});
    expq.push_back({AW'(18'h555), 16'h00AA});
    expq.push_back({AW'(18'h2AA), 16'h0055});
    if (op == 2'b00)  expq.push_back({AW'(18'h555), 16'h0010});
    else if (!op[1])  expq.push_back({a, 16'h0050});
    else              expq.push_back({a, 16'h0030});
    want = 2;
    if (nt + 1 > want) want = nt + 1;
    if (ur && nr > want) want = nr;
    if (exp_err) want = MAXP;
    @(negedge clk);
    base = reads; ntog = nt; nry = nr;
    req_valid = 1; req_op = op; req_addr = a; use_rdy = ur;
    @(negedge clk);
    req_valid = 0;
    check(busy, "R10", "busy after request", busy, 1);
    cyc = 0;
    while (!done && cyc < 5000) begin
      if (intrude && cyc == 20) begin req_valid = 1; req_op = 2'b01; req_addr = 18'h3F000; end
      if (intrude && cyc == 21) req_valid = 0;
      @(negedge clk);
      cyc++;
    end
    check(done, "R10", "done seen before watchdog", done, 1);
    check(error == exp_err, exp_err ? "R8" : "R6", "error flag", error, exp_err);
    check(reads - base == want, ur ? "R7" : (exp_err ? "R8" : "R6"), "poll reads",
          reads - base, want);
    check(!busy, "R10", "busy low with done", busy, 0);
    check(expq.size() == 0, "R2", "writes left", expq.size(), 0);
    @(negedge clk);
    check(!done && !error, "R10", "done one clock", {done, error}, 0);
    if (intrude) begin
      repeat (10) @(negedge clk);
      check(!busy && flash_ce_n, "R9", "no op after ignored request", busy, 0);
    end
    expq.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe && !busy && !done && !error,
          "R1", "reset state", {flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe, busy},
          5'b11100);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!busy && flash_ce_n, "R1", "idle after reset", busy, 0);
    run_op(2'b00, 18'h00000, 0, 0, 0, 0, 0);   // R3 chip, R6 minimal reads
    run_op(2'b01, 18'h1A000, 5, 0, 0, 0, 0);   // R3 sector, R6 odd toggles
    run_op(2'b10, 18'h30000, 3, 0, 0, 0, 0);   // R3 block
    run_op(2'b11, 18'h21000, 2, 9, 1, 0, 0);   // R7 wait for ready
    run_op(2'b01, 18'h02000, 2, 9, 0, 0, 0);   // R7 ready ignored
    run_op(2'b00, 18'h00000, 100, 0, 0, 1, 0); // R8 timeout
    run_op(2'b10, 18'h11000, 4, 0, 0, 0, 1);   // R9 request while busy
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule